// File: doc/BRIEF.md
# Host-Priority Shared Memory Bus Arbiter

This block sits between a host port and a signal-processor port that share one memory bus, and it always favours the host. When the host starts a shared-memory access, the block asks the processor to give up the bus with a hold request. It also stretches the host cycle with a wait signal until the processor acknowledges. Once the acknowledge arrives, the bus is granted to the host. The hold request is withdrawn on the clock after the host chip-enable falls, which hands the bus back to the processor.

Some accesses skip the handshake entirely:
- Accesses to the on-block control and communication registers never disturb the processor.
- Accesses to a protected low region of the shared memory are refused while the processor runs.
- When the processor is disabled, or its clock is stopped, the host is granted the bus at once.

If the acknowledge never arrives, a fixed time-out releases the host, discards the access and raises a sticky flag.

Top module: `shmem_host_arb`

## Requirements
- R1: In smart mode (`mode_smart`=1) with the processor clock running (`dsp_clk_on`=1), a host memory access raises `dsp_hold` from the first clock edge after `host_ce` rises.
- R2: During such a handshake, `host_wait` is high from the cycle `host_ce` rises until the cycle in which `host_grant` rises or the time-out is taken, and `host_wait` and `host_grant` are never high together.
- R3: In handshake mode, `host_grant` rises only on the clock after `dsp_holda` was sampled high; `host_wait` falls in that same cycle.
- R4: `dsp_hold` is low on the clock after `host_ce` is sampled low.
- R5: If `dsp_holda` has not been sampled high after TMO_CYC (64) cycles with `dsp_hold` high, `host_wait` and `dsp_hold` drop, `host_grant` stays low for the rest of the access, and `tmo_flag` sets.
- R6: An access with `host_reg_sel`=1 never raises `dsp_hold`, `host_wait` or `host_grant`.
- R7: In smart mode, a memory access with `host_addr` below PROT_BYTES (16) raises `host_blocked` and none of `dsp_hold`, `host_wait` or `host_grant`.
- R8: In standard mode (`mode_smart`=0), a memory access gets `host_grant` in the same cycle without hold or wait, and the low region is not protected.
- R9: In smart mode with `dsp_clk_on`=0, a non-protected memory access gets `host_grant` in the same cycle without hold or wait.
- R10: After reset all outputs are low; `tmo_flag` stays set once set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_smart | input | 1 | 1 = smart mode (processor enabled), 0 = standard mode |
| dsp_clk_on | input | 1 | Processor clock is running |
| host_ce | input | 1 | Host access active; the access ends when it falls |
| host_reg_sel | input | 1 | Access targets the on-block registers, not memory |
| host_addr | input | ADDR_W | Host byte address within shared memory |
| dsp_holda | input | 1 | Processor hold acknowledge |
| dsp_hold | output | 1 | Hold request to the processor |
| host_wait | output | 1 | Stretch the host cycle |
| host_grant | output | 1 | Shared bus driven for the host |
| host_blocked | output | 1 | Access refused (protected region) |
| tmo_flag | output | 1 | Sticky hold time-out status |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 16-byte protected region and a 64-cycle time-out. The time-out is short enough that every random handshake in which the processor never answers runs to expiry. Each such run counts the wait cycles exactly. A processor model answers after a random latency that stays well below the time-out, or not at all. Random choices of mode, processor clock, register select and address reach every bypass path, and both sides of the protected-region boundary are covered.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_REQ  = 2'd1,
      ARB_GNT  = 2'd2,
      ARB_TMO  = 2'd3
   } arb_state_t;
endpackage

// File: rtl/shmem_acc_class.sv
module shmem_acc_class #(
   parameter int ADDR_W     = 16,
   parameter int PROT_BYTES = 16
) (
   input  logic              smart,
   input  logic              ce,
   input  logic              reg_sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              mem_acc,
   output logic              prot_hit
);
   logic low_region;

   generate
      if (PROT_BYTES == 0) begin : g_noprot
         assign low_region = 1'b0;
      end else begin : g_prot
         localparam logic [ADDR_W-1:0] PROT_LIM = ADDR_W'(PROT_BYTES);
         assign low_region = (addr < PROT_LIM);
      end
   endgenerate

   assign prot_hit = ce & ~reg_sel & smart & low_region;
   assign mem_acc  = ce & ~reg_sel & ~prot_hit;
endmodule

// File: rtl/shmem_tmo_cnt.sv
module shmem_tmo_cnt #(
   parameter int TMO_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expired = run & (cnt == LAST);
endmodule

// File: rtl/shmem_host_arb.sv
module shmem_host_arb
   import shmem_arb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PROT_BYTES = 16,
   parameter int TMO_CYC    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_smart,
   input  logic              dsp_clk_on,
   input  logic              host_ce,
   input  logic              host_reg_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              dsp_holda,
   output logic              dsp_hold,
   output logic              host_wait,
   output logic              host_grant,
   output logic              host_blocked,
   output logic              tmo_flag
);
   initial begin
      if (ADDR_W < 4 || ADDR_W > 32) $error("ADDR_W out of range");
      if (TMO_CYC < 2) $error("TMO_CYC must be at least 2");
      if (PROT_BYTES < 0 || PROT_BYTES >= (1 << ADDR_W)) $error("PROT_BYTES out of range");
   end

   arb_state_t st, st_nxt;
   logic mem_acc, prot_hit, hs_en, need_hs, direct, expired;

   shmem_acc_class #(.ADDR_W(ADDR_W), .PROT_BYTES(PROT_BYTES)) u_class (
      .smart    (mode_smart),
      .ce       (host_ce),
      .reg_sel  (host_reg_sel),
      .addr     (host_addr),
      .mem_acc  (mem_acc),
      .prot_hit (prot_hit)
   );

   shmem_tmo_cnt #(.TMO_CYC(TMO_CYC)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == ARB_REQ && hs_en && host_ce && !dsp_holda),
      .expired (expired)
   );

   assign hs_en   = mode_smart & dsp_clk_on;
   assign need_hs = mem_acc & hs_en;
   assign direct  = mem_acc & ~hs_en;

   always_comb begin
      st_nxt = st;
      if (!hs_en) begin
         st_nxt = ARB_IDLE;
      end else begin
         unique case (st)
            ARB_IDLE: if (need_hs) st_nxt = ARB_REQ;
            ARB_REQ: begin
               if (!host_ce)       st_nxt = ARB_IDLE;
               else if (dsp_holda) st_nxt = ARB_GNT;
               else if (expired)   st_nxt = ARB_TMO;
            end
            ARB_GNT: if (!host_ce) st_nxt = ARB_IDLE;
            ARB_TMO: if (!host_ce) st_nxt = ARB_IDLE;
            default: st_nxt = ARB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ARB_IDLE;
         tmo_flag <= 1'b0;
      end else begin
         st <= st_nxt;
         if (st == ARB_REQ && st_nxt == ARB_TMO) tmo_flag <= 1'b1;
      end
   end

   assign dsp_hold     = hs_en & (st == ARB_REQ || st == ARB_GNT);
   assign host_wait    = hs_en & ((st == ARB_IDLE && need_hs) || (st == ARB_REQ && host_ce));
   assign host_grant   = direct | (hs_en & host_ce & (st == ARB_GNT));
   assign host_blocked = prot_hit;
endmodule

// File: rtl/shmem_host_arb_chk.sv
module shmem_host_arb_chk #(
   parameter int ADDR_W     = 16,
   parameter int PROT_BYTES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_smart,
   input logic              dsp_clk_on,
   input logic              host_ce,
   input logic              host_reg_sel,
   input logic [ADDR_W-1:0] host_addr,
   input logic              dsp_holda,
   input logic              dsp_hold,
   input logic              host_wait,
   input logic              host_grant,
   input logic              host_blocked,
   input logic              tmo_flag
);
   assert_wait_grant_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wait && host_grant));

   assert_hold_stalls_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_hold && host_ce && !host_grant) |-> host_wait);

   assert_grant_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(host_grant) && mode_smart && dsp_clk_on) |-> $past(dsp_holda));

   assert_hold_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_ce && mode_smart && dsp_clk_on) |=> !dsp_hold);

   assert_tmo_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_flag |=> tmo_flag);

   assert_reg_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ce && host_reg_sel) |-> (!host_wait && !host_grant && !host_blocked));

   assert_prot_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_smart && host_ce && !host_reg_sel && host_addr < ADDR_W'(PROT_BYTES))
         |-> (host_blocked && !host_wait && !host_grant));

   assert_std_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_smart |-> (!dsp_hold && !host_wait && !host_blocked));

   assert_clkoff_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dsp_clk_on |-> (!dsp_hold && !host_wait));
endmodule

bind shmem_host_arb shmem_host_arb_chk #(.ADDR_W(ADDR_W), .PROT_BYTES(PROT_BYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_smart   (mode_smart),
   .dsp_clk_on   (dsp_clk_on),
   .host_ce      (host_ce),
   .host_reg_sel (host_reg_sel),
   .host_addr    (host_addr),
   .dsp_holda    (dsp_holda),
   .dsp_hold     (dsp_hold),
   .host_wait    (host_wait),
   .host_grant   (host_grant),
   .host_blocked (host_blocked),
   .tmo_flag     (tmo_flag)
);

// File: tb/shmem_host_arb_tb.sv
`timescale 1ns/1ps
module shmem_host_arb_tb;
   localparam int ADDR_W = 16;
   localparam int PROT   = 16;
   localparam int TMO    = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_smart = 1'b0, dsp_clk_on = 1'b0, host_ce = 1'b0, host_reg_sel = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic dsp_holda = 1'b0;
   logic dsp_hold, host_wait, host_grant, host_blocked, tmo_flag;

   int checks = 0;
   int errors = 0;
   bit tmo_seen = 1'b0;

   always #10 clk = ~clk;

   shmem_host_arb #(.ADDR_W(ADDR_W), .PROT_BYTES(PROT), .TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_smart(mode_smart), .dsp_clk_on(dsp_clk_on),
      .host_ce(host_ce), .host_reg_sel(host_reg_sel), .host_addr(host_addr),
      .dsp_holda(dsp_holda), .dsp_hold(dsp_hold), .host_wait(host_wait),
      .host_grant(host_grant), .host_blocked(host_blocked), .tmo_flag(tmo_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected outputs {hold,wait,grant,blocked} of a bypass access
   function automatic logic [3:0] exp_bypass(input bit smart, input bit reg_s, input int addr);
      if (reg_s) return 4'b0000;
      if (smart && addr < PROT) return 4'b0001;
      return 4'b0010;
   endfunction

   task automatic access(input bit smart, input bit clk_on, input bit reg_s,
                         input int addr, input int lat);
      bit hs;
      int hcnt, wcnt;
      bit done;
      @(negedge clk);
      mode_smart = smart; dsp_clk_on = clk_on;
      @(negedge clk);
      host_reg_sel = reg_s; host_addr = ADDR_W'(addr); host_ce = 1'b1;
      hs = smart && clk_on && !reg_s && addr >= PROT;
      #1;
      if (!hs) begin
         for (int i = 0; i < 3; i++) begin
            chk(reg_s ? "R6" : (!smart ? "R8" : (addr < PROT ? "R7" : "R9")),
                {dsp_hold, host_wait, host_grant, host_blocked},
                exp_bypass(smart, reg_s, addr));
            @(negedge clk);
         end
      end else begin
         chk("R2 wait at start", {host_wait, host_grant}, 2'b10);
         hcnt = 0; wcnt = 0; done = 1'b0;
         for (int i = 0; i < TMO + 20 && !done; i++) begin
            @(negedge clk);
            if (i == 0) chk("R1 hold raised", dsp_hold, 1'b1);
            if (host_grant) begin
               chk("R3 grant after ack", {lat >= 0, dsp_hold, host_wait}, 3'b110);
               chk("R3 ack latency", wcnt, lat + 1);
               done = 1'b1;
            end else if (!host_wait) begin
               chk("R5 timeout cycles", wcnt, TMO);
               chk("R5 timeout state", {lat < 0, dsp_hold, tmo_flag}, 3'b101);
               tmo_seen = 1'b1;
               done = 1'b1;
            end else begin
               wcnt++;
               if (dsp_hold) hcnt++;
               if (lat >= 0 && hcnt > lat) dsp_holda = 1'b1;
            end
         end
         if (!done) chk("R2 access resolved", 1'b0, 1'b1);
         @(negedge clk);
         chk("R5 no late grant", host_grant, (lat >= 0) ? 1'b1 : 1'b0);
      end
      host_ce = 1'b0;
      @(negedge clk);
      chk("R4 hold dropped", {dsp_hold, host_grant, host_wait}, 3'b000);
      dsp_holda = 1'b0;
      chk("R10 sticky flag", tmo_flag, tmo_seen);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      #35;
      chk("R10 reset", {dsp_hold, host_wait, host_grant, host_blocked, tmo_flag}, 5'b0);
      @(negedge clk); rst_n = 1'b1;
      // directed corners
      access(1, 1, 0, PROT, 0);        // R1/R3 immediate ack
      access(1, 1, 0, PROT - 1, 0);    // R7 boundary below
      access(0, 0, 0, 0, 0);           // R8 low region open in standard mode
      access(1, 0, 0, 100, 0);         // R9 clock off
      access(1, 1, 1, 0, 0);           // R6 register access
      access(1, 1, 0, 200, -1);        // R5 timeout
      access(1, 1, 0, 300, 5);         // R10 flag kept
      for (int n = 0; n < 250; n++) begin
         bit sm, co, rs;
         int ad, lt;
         sm = ($urandom % 4) != 0;
         co = ($urandom % 5) != 0;
         rs = ($urandom % 6) == 0;
         ad = ($urandom % 3 == 0) ? int'($urandom % 32) : int'($urandom % 65536);
         lt = ($urandom % 8 == 0) ? -1 : int'($urandom % 40);
         access(sm, co, rs, ad, lt);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule